// File: doc/BRIEF.md
# MAC Control Frame Filter

The filter sits on the receive path of an Ethernet MAC and inspects each incoming frame one byte per accepted beat. A beat is accepted when `in_valid` is high; `in_sof` marks the first byte of a frame and `in_eof` marks the last. From the header the block learns whether the frame is a MAC Control frame and, if so, which opcode it carries.

At the last byte of every frame it issues a one-cycle verdict that tells the downstream buffer logic whether to pass the frame to the host or throw it away. PAUSE frames never reach the host. They are dropped, and a one-cycle pause request carrying the 16-bit pause time goes to the transmit side. Control frames with any other opcode go to the host like ordinary traffic.

The host cannot see PAUSE traffic, so the block keeps three wrapping statistics counters: one for all control frames, one for control frames with an unsupported opcode, and one for PAUSE frames. The host can zero each counter with its own synchronous clear.

Top module: `mcf_filter`

## Requirements
- R1: A frame is a MAC Control frame only when byte 12 is 0x88, byte 13 is 0x08 and the frame has at least 16 bytes. Bytes are numbered from 0 at the start-of-frame byte. The opcode is byte 14 (high) followed by byte 15 (low).
- R2: A control frame with opcode 0x0001 is a PAUSE frame. Its verdict has `fwd_drop` = 1.
- R3: `pause_req` is high for exactly the verdict cycle of a PAUSE frame. In that cycle `pause_quanta` = {byte 16, byte 17}, and any of those bytes that the frame did not contain read as 0x00.
- R4: A control frame with any other opcode gets a verdict with `fwd_drop` = 0 and no pause request.
- R5: A frame that is not a control frame gets a verdict with `fwd_drop` = 0, raises no pause request and leaves all counters unchanged.
- R6: `fwd_valid` is high for exactly one cycle, the cycle after each accepted end-of-frame byte, and at no other time.
- R7: `ctrl_cnt` increments once for every control frame, whatever its opcode. The counter and the verdict become visible in the same cycle.
- R8: `unsup_cnt` increments once for every control frame whose opcode is not 0x0001.
- R9: `pause_cnt` increments once for every PAUSE frame.
- R10: Each counter is CNT_W bits wide (32 by default) and wraps to zero modulo 2^CNT_W.
- R11: A high clear input zeroes its counter on the next cycle. If the clear and an increment happen in the same cycle, the clear wins.
- R12: A frame that ends before its byte 15 (fewer than 16 bytes) is forwarded as a normal frame and changes no counter, even if bytes 12 and 13 are 0x88 0x08.
- R13: A start-of-frame byte restarts parsing at byte 0, even in the middle of a frame. A byte accepted after an end-of-frame byte begins a new frame. Beats with `in_valid` low are ignored, whatever `in_sof`, `in_eof` and `in_data` hold.
- R14: After reset, `fwd_valid`, `fwd_drop`, `pause_req`, `pause_quanta` and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte beat accepted |
| in_sof | input | 1 | Beat is the first byte of a frame |
| in_eof | input | 1 | Beat is the last byte of a frame |
| in_data | input | 8 | Frame byte |
| clr_ctrl_cnt | input | 1 | Clear the control-frame counter |
| clr_unsup_cnt | input | 1 | Clear the unsupported-opcode counter |
| clr_pause_cnt | input | 1 | Clear the PAUSE counter |
| fwd_valid | output | 1 | Verdict strobe, one cycle per frame |
| fwd_drop | output | 1 | Verdict: discard the frame |
| pause_req | output | 1 | Pause request pulse |
| pause_quanta | output | 16 | Pause time carried with the request |
| ctrl_cnt | output | CNT_W | Control frames received |
| unsup_cnt | output | CNT_W | Unsupported-opcode control frames received |
| pause_cnt | output | CNT_W | PAUSE frames received |

## Verification
The bench targets several corner cases:
- Frames of 14, 15, 16 and 17 bytes. A design that counted the EtherType without the opcode would miscount them, and one that left quanta bytes stale would raise a pause with the wrong time.
- A restart in mid-frame, back-to-back frames with no idle beat, and idle beats that carry stray start and end flags. A parser that mishandles any of these would misplace the header offsets or emit extra verdicts.
- A near-miss EtherType, 0x8809, which must be treated as ordinary traffic.
- A clear that lands on a frame's last byte, which must win over the increment.
- A narrow-counter instance, which shows the counters wrapping instead of saturating.

// File: rtl/mcf_pkg.sv
package mcf_pkg;

    localparam int HDR_BYTES = 18;
    localparam int IDX_W     = $clog2(HDR_BYTES + 1);

    localparam int OFS_TYPE  = 12;
    localparam int OFS_OPC   = 14;
    localparam int OFS_QNT   = 16;

    localparam logic [15:0] ETYPE_MAC_CTRL = 16'h8808;
    localparam logic [15:0] OPC_PAUSE      = 16'h0001;

    localparam int NUM_CNT   = 3;
    localparam int CNT_CTRL  = 0;
    localparam int CNT_UNSUP = 1;
    localparam int CNT_PAUSE = 2;

    typedef struct packed {
        logic [15:0] etype;
        logic [15:0] opcode;
        logic [15:0] quanta;
        logic        opc_seen;
    } hdr_t;

    typedef enum logic [1:0] {
        FR_NORMAL     = 2'd0,
        FR_PAUSE      = 2'd1,
        FR_CTRL_OTHER = 2'd2
    } frame_kind_e;

    typedef struct packed {
        logic        valid;
        logic        drop;
        logic        pause;
        logic [15:0] quanta;
    } verdict_t;

    function automatic hdr_t hdr_insert(hdr_t h, logic [IDX_W-1:0] pos, logic [7:0] b);
        hdr_t r;
        r = h;
        case (int'(pos))
            OFS_TYPE:     r.etype[15:8]  = b;
            OFS_TYPE + 1: r.etype[7:0]   = b;
            OFS_OPC:      r.opcode[15:8] = b;
            OFS_OPC + 1: begin
                r.opcode[7:0] = b;
                r.opc_seen    = 1'b1;
            end
            OFS_QNT:      r.quanta[15:8] = b;
            OFS_QNT + 1:  r.quanta[7:0]  = b;
            default:      r = h;
        endcase
        return r;
    endfunction

    function automatic frame_kind_e classify(hdr_t h);
        if (!h.opc_seen || h.etype != ETYPE_MAC_CTRL)
            return FR_NORMAL;
        else if (h.opcode == OPC_PAUSE)
            return FR_PAUSE;
        else
            return FR_CTRL_OTHER;
    endfunction

endpackage

// File: rtl/mcf_hdr_parser.sv
module mcf_hdr_parser
    import mcf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       in_sof,
    input  logic       in_eof,
    input  logic [7:0] in_data,
    output logic       frame_end,
    output hdr_t       hdr_now
);

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] pos;
    logic [IDX_W-1:0] pos_inc;
    hdr_t             hdr_q;
    hdr_t             base;

    always_comb begin
        pos       = in_sof ? '0 : idx_q;
        base      = in_sof ? '0 : hdr_q;
        hdr_now   = hdr_insert(base, pos, in_data);
        pos_inc   = (pos == IDX_W'(HDR_BYTES)) ? pos : pos + 1'b1;
        frame_end = in_valid && in_eof;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            hdr_q <= '0;
        end else if (in_valid) begin
            if (in_eof) begin
                idx_q <= '0;
                hdr_q <= '0;
            end else begin
                idx_q <= pos_inc;
                hdr_q <= hdr_now;
            end
        end
    end

    // R13: a start byte places the parser on byte 1 for the following beat
    a_r13_sof_restart: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sof && !in_eof) |=> (idx_q == IDX_W'(1)));

    // R13: idle beats leave the byte position untouched
    a_r13_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(idx_q));

    // R13: after an end byte the next frame starts from zero
    a_r13_eof_rewind: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_eof) |=> (idx_q == '0));

endmodule

// File: rtl/mcf_classifier.sv
module mcf_classifier
    import mcf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_end,
    input  hdr_t               hdr_now,
    output verdict_t           verdict,
    output logic [NUM_CNT-1:0] inc_vec
);

    frame_kind_e kind;
    verdict_t    verdict_q;

    always_comb begin
        kind               = classify(hdr_now);
        inc_vec            = '0;
        inc_vec[CNT_CTRL]  = frame_end && (kind != FR_NORMAL);
        inc_vec[CNT_UNSUP] = frame_end && (kind == FR_CTRL_OTHER);
        inc_vec[CNT_PAUSE] = frame_end && (kind == FR_PAUSE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict_q <= '0;
        end else begin
            verdict_q.valid <= frame_end;
            verdict_q.drop  <= frame_end && (kind == FR_PAUSE);
            verdict_q.pause <= frame_end && (kind == FR_PAUSE);
            if (frame_end && kind == FR_PAUSE)
                verdict_q.quanta <= hdr_now.quanta;
        end
    end

    assign verdict = verdict_q;

    // R4: a forwarded frame never carries a pause request
    a_r4_forward_no_pause: assert property (@(posedge clk) disable iff (rst)
        (verdict_q.valid && !verdict_q.drop) |-> !verdict_q.pause);

    // R7: every unsupported or PAUSE count goes with a control count
    a_r7_ctrl_covers: assert property (@(posedge clk) disable iff (rst)
        (inc_vec[CNT_UNSUP] || inc_vec[CNT_PAUSE]) |-> inc_vec[CNT_CTRL]);

    // R8: unsupported and PAUSE never counted together
    a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
        $countones(inc_vec[CNT_PAUSE:CNT_UNSUP]) <= 1);

endmodule

// File: rtl/mcf_stat_counter.sv
module mcf_stat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst || clr)
            q <= '0;
        else if (inc)
            q <= q + W'(1);
    end

    // R11: a clear wins over a coincident increment
    a_r11_clear_wins: assert property (@(posedge clk) disable iff (rst)
        clr |=> (q == '0));

    // R10: increments step by one and wrap naturally
    a_r10_step_wrap: assert property (@(posedge clk) disable iff (rst)
        (!clr && inc) |=> (q == $past(q) + W'(1)));

    // R7: without clear or increment the count holds
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr && !inc) |=> $stable(q));

endmodule

// File: rtl/mcf_filter.sv
module mcf_filter
    import mcf_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [7:0]       in_data,
    input  logic             clr_ctrl_cnt,
    input  logic             clr_unsup_cnt,
    input  logic             clr_pause_cnt,
    output logic             fwd_valid,
    output logic             fwd_drop,
    output logic             pause_req,
    output logic [15:0]      pause_quanta,
    output logic [CNT_W-1:0] ctrl_cnt,
    output logic [CNT_W-1:0] unsup_cnt,
    output logic [CNT_W-1:0] pause_cnt
);

    logic               frame_end;
    hdr_t               hdr_now;
    verdict_t           verdict;
    logic [NUM_CNT-1:0] inc_vec;
    logic [NUM_CNT-1:0] clr_vec;
    logic [CNT_W-1:0]   cnt_arr [NUM_CNT];

    mcf_hdr_parser u_parser (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_eof    (in_eof),
        .in_data   (in_data),
        .frame_end (frame_end),
        .hdr_now   (hdr_now)
    );

    mcf_classifier u_class (
        .clk       (clk),
        .rst       (rst),
        .frame_end (frame_end),
        .hdr_now   (hdr_now),
        .verdict   (verdict),
        .inc_vec   (inc_vec)
    );

    always_comb begin
        clr_vec            = '0;
        clr_vec[CNT_CTRL]  = clr_ctrl_cnt;
        clr_vec[CNT_UNSUP] = clr_unsup_cnt;
        clr_vec[CNT_PAUSE] = clr_pause_cnt;
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        mcf_stat_counter #(.W(CNT_W)) u_cnt (
            .clk (clk),
            .rst (rst),
            .clr (clr_vec[g]),
            .inc (inc_vec[g]),
            .q   (cnt_arr[g])
        );
    end

    assign fwd_valid    = verdict.valid;
    assign fwd_drop     = verdict.drop;
    assign pause_req    = verdict.pause;
    assign pause_quanta = verdict.quanta;
    assign ctrl_cnt     = cnt_arr[CNT_CTRL];
    assign unsup_cnt    = cnt_arr[CNT_UNSUP];
    assign pause_cnt    = cnt_arr[CNT_PAUSE];

    // R6: a verdict only follows an accepted end byte
    a_r6_verdict_after_eof: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> $past(in_valid && in_eof));

    // R6: every accepted end byte yields a verdict
    a_r6_eof_gives_verdict: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_eof) |=> fwd_valid);

    // R3: a pause request rides on a dropping verdict
    a_r3_pause_with_drop: assert property (@(posedge clk) disable iff (rst)
        pause_req |-> (fwd_valid && fwd_drop));

    // R2: only PAUSE frames are dropped
    a_r2_drop_is_pause: assert property (@(posedge clk) disable iff (rst)
        fwd_drop |-> pause_req);

    // R9: a PAUSE count rise coincides with a pause request
    a_r9_pause_count_pulse: assert property (@(posedge clk) disable iff (rst)
        (pause_cnt != $past(pause_cnt) && pause_cnt != '0) |-> pause_req);

endmodule

// File: tb/tb_mcf_filter.sv
module tb_mcf_filter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic        in_eof = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        clr_c = 1'b0, clr_u = 1'b0, clr_p = 1'b0;

    logic        fv, fd, pr;
    logic [15:0] pq;
    logic [31:0] cc, cu, cp;
    logic        w_fv, w_fd, w_pr;
    logic [15:0] w_pq;
    logic [2:0]  wc, wu, wp;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mcf_filter dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .in_data(in_data), .clr_ctrl_cnt(clr_c), .clr_unsup_cnt(clr_u), .clr_pause_cnt(clr_p),
        .fwd_valid(fv), .fwd_drop(fd), .pause_req(pr), .pause_quanta(pq),
        .ctrl_cnt(cc), .unsup_cnt(cu), .pause_cnt(cp)
    );

    mcf_filter #(.CNT_W(3)) dut_w (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .in_data(in_data), .clr_ctrl_cnt(clr_c), .clr_unsup_cnt(clr_u), .clr_pause_cnt(clr_p),
        .fwd_valid(w_fv), .fwd_drop(w_fd), .pause_req(w_pr), .pause_quanta(w_pq),
        .ctrl_cnt(wc), .unsup_cnt(wu), .pause_cnt(wp)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0]  frm[$];
    bit          e_vv, e_drop, e_pr;
    logic [15:0] e_q = 16'h0;
    longint      e_cnt[3];

    always @(posedge clk) begin
        bit ic, iu, ip;
        logic [15:0] opc;
        ic = 0; iu = 0; ip = 0;
        if (rst) begin
            frm.delete();
            e_vv = 0; e_drop = 0; e_pr = 0; e_q = 16'h0;
            for (int k = 0; k < 3; k++) e_cnt[k] = 0;
        end else begin
            e_vv = 0; e_drop = 0; e_pr = 0;
            if (in_valid) begin
                if (in_sof) frm.delete();
                frm.push_back(in_data);
                if (in_eof) begin
                    e_vv = 1;
                    if (frm.size() >= 16 && frm[12] == 8'h88 && frm[13] == 8'h08) begin
                        ic  = 1;
                        opc = {frm[14], frm[15]};
                        if (opc == 16'h0001) begin
                            ip = 1; e_drop = 1; e_pr = 1;
                            e_q = {(frm.size() > 16) ? frm[16] : 8'h00,
                                   (frm.size() > 17) ? frm[17] : 8'h00};
                        end else begin
                            iu = 1;
                        end
                    end
                    frm.delete();
                end
            end
            if (clr_c) e_cnt[0] = 0; else if (ic) e_cnt[0]++;
            if (clr_u) e_cnt[1] = 0; else if (iu) e_cnt[1]++;
            if (clr_p) e_cnt[2] = 0; else if (ip) e_cnt[2]++;
        end
    end

    // per-cycle comparison, away from the edge
    always @(posedge clk) begin
        #2;
        if (!done) begin
            chk("R6 fwd_valid", fv, e_vv);
            chk("R6 fwd_valid narrow", w_fv, e_vv);
            if (e_vv) chk("R2 R4 R5 fwd_drop", fd, e_drop);
            chk("R3 pause_req", pr, e_pr);
            if (e_pr) chk("R3 pause_quanta", pq, e_q);
            chk("R7 ctrl_cnt", cc, e_cnt[0] & 32'hFFFF_FFFF);
            chk("R8 unsup_cnt", cu, e_cnt[1] & 32'hFFFF_FFFF);
            chk("R9 pause_cnt", cp, e_cnt[2] & 32'hFFFF_FFFF);
            chk("R10 ctrl_cnt narrow", wc, e_cnt[0] & 7);
            chk("R10 unsup_cnt narrow", wu, e_cnt[1] & 7);
            chk("R10 pause_cnt narrow", wp, e_cnt[2] & 7);
        end
    end

    // ---------------- stimulus helpers ----------------
    logic [7:0] fb[$];

    task automatic make_frame(input logic [15:0] et, input logic [15:0] op,
                              input logic [15:0] qn, input int len);
        fb.delete();
        for (int i = 0; i < len; i++) begin
            case (i)
                12: fb.push_back(et[15:8]);
                13: fb.push_back(et[7:0]);
                14: fb.push_back(op[15:8]);
                15: fb.push_back(op[7:0]);
                16: fb.push_back(qn[15:8]);
                17: fb.push_back(qn[7:0]);
                default: fb.push_back(8'(i * 13 + len));
            endcase
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 0; in_sof = 1; in_eof = 1; in_data = 8'hA5;
            clr_c = 0; clr_u = 0; clr_p = 0;
        end
    endtask

    task automatic drive(input int sof2, input logic [2:0] clr_end);
        for (int i = 0; i < fb.size(); i++) begin
            @(negedge clk);
            in_valid = 1;
            in_sof   = (i == 0) || (i == sof2);
            in_eof   = (i == fb.size() - 1);
            in_data  = fb[i];
            {clr_p, clr_u, clr_c} = (i == fb.size() - 1) ? clr_end : 3'b000;
        end
    endtask

    task automatic send(input logic [15:0] et, input logic [15:0] op,
                        input logic [15:0] qn, input int len);
        make_frame(et, op, qn, len);
        drive(-1, 3'b000);
        idle(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [31:0] c0, u0, p0;
        repeat (4) @(negedge clk);
        // R14: reset values
        chk("R14 fwd_valid", fv, 0);
        chk("R14 pause_quanta", pq, 0);
        chk("R14 counters", {cc, cu, cp}, 0);
        rst = 0;
        idle(2);

        send(16'h0800, 16'h0000, 16'h0000, 64);          // R5 ordinary frame
        send(16'h8808, 16'h0001, 16'h1234, 64);          // R2 R3 PAUSE
        send(16'h8808, 16'h0002, 16'hBEEF, 60);          // R4 other opcode
        // R1: near-miss EtherType is not a control frame
        c0 = cc;
        send(16'h8809, 16'h0001, 16'h0011, 64);
        chk("R1 near-miss type not counted", cc, c0);

        // R12: short frames carrying the control type
        c0 = cc; u0 = cu; p0 = cp;
        send(16'h8808, 16'h0001, 16'h0000, 14);
        send(16'h8808, 16'h0001, 16'h0000, 15);
        chk("R12 ctrl_cnt after short", cc, c0);
        chk("R12 pause_cnt after short", cp, p0);

        // R3: 16- and 17-byte PAUSE frames, missing quanta bytes read as zero
        send(16'h8808, 16'h0001, 16'hFFFF, 16);
        send(16'h8808, 16'h0001, 16'h7766, 17);

        // R13: restart in mid-frame
        p0 = cp;
        make_frame(16'h0800, 16'h0000, 16'h0000, 10);
        begin
            logic [7:0] pre[$];
            pre = fb;
            make_frame(16'h8808, 16'h0001, 16'h0A0B, 64);
            fb = {pre, fb};
        end
        drive(10, 3'b000);
        idle(2);
        chk("R13 restart parsed as PAUSE", cp, p0 + 1);

        // R13: back-to-back frames without sof on the second one
        make_frame(16'h8808, 16'h0003, 16'h0000, 20);
        begin
            logic [7:0] first[$];
            first = fb;
            make_frame(16'h8808, 16'h0001, 16'h4321, 20);
            drive_pair(first, fb);
        end
        idle(3);

        // R11: clear coincident with an increment
        make_frame(16'h8808, 16'h0001, 16'h0005, 64);
        drive(-1, 3'b101);
        idle(2);
        chk("R11 ctrl cleared over increment", cc, 0);
        chk("R11 pause cleared over increment", cp, 0);
        @(negedge clk); clr_u = 1;
        @(negedge clk); clr_u = 0;
        chk("R11 unsup cleared", cu, 0);
        idle(1);

        // R10: narrow counters wrap
        for (int i = 0; i < 9; i++) begin
            make_frame(16'h8808, 16'h0100 + 16'(i), 16'h0000, 18);
            drive(-1, 3'b000);
        end
        idle(3);
        chk("R10 narrow unsup wraps", wu, 1);
        chk("R8 unsup after burst", cu, 9);

        idle(4);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    task automatic drive_pair(input logic [7:0] a[$], input logic [7:0] b[$]);
        for (int i = 0; i < a.size() + b.size(); i++) begin
            @(negedge clk);
            in_valid = 1;
            in_sof   = (i == 0);
            in_eof   = (i == a.size() - 1) || (i == a.size() + b.size() - 1);
            in_data  = (i < a.size()) ? a[i] : b[i - a.size()];
            {clr_p, clr_u, clr_c} = 3'b000;
        end
    endtask

endmodule